// File: doc/BRIEF.md
# Pin Controller with Edge-Event Interrupts

This block is a memory-mapped general-purpose pin controller for 32 pads. It has a single-cycle register port: a write takes effect at the clock edge and a read is combinational from the address. Each pin has three configuration bits, each held in its own register: a direction bit, an open-drain select and an output latch. Pin levels pass through a two-stage synchronizer. Rising and falling edges then set per-pin event latches, and software clears those latches by writing ones to them.

A per-pin enable gates the events. From the gated events the block raises one combined interrupt line and reports which pending pin is served first. A build parameter selects how each pin's sense is configured:
- The narrow variant uses one bit per pin to choose falling-only or both edges.
- The wide variant uses a two-bit code per pin, split over two registers. In this variant a second parameter can make some pins input-only.

Pins are numbered from the most significant bit: pin n lives in register bit 31-n.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero, `irq` is low and no pad is driven (`pad_oe` all zero).
- R2: Pin n maps to bit 31-n of every register and pad vector. Byte offsets on `bus_addr` are: direction 0x00, open-drain 0x04, data 0x08, event 0x0C, enable 0x10, sense 0x14, second sense 0x18. A direction bit of 1 drives the pad (`pad_oe`=1) and 0 leaves it an input.
- R3: For an output pin with its open-drain bit set, the pad is driven low when the latch is 0 and released when the latch is 1. `pad_out` is always the latch ANDed with NOT open-drain.
- R4: Reading the data register returns the output latch for output pins and the synchronized pad level for input pins. The pad level reaches the read value two clock edges after it is sampled.
- R5: In the narrow variant (`SENSE_2BIT`=0), a sense bit of 1 latches an event only on a falling edge, and 0 latches on both edges. The second sense register reads zero and ignores writes.
- R6: In the wide variant, pins 0–15 take their 2-bit code from the register at 0x14 and pins 16–31 from 0x18. Pin 0 and pin 16 each sit at bits 31:30 of their register. The codes are: 00 both edges, 01 rising, 10 falling, 11 no event.
- R7: Writing the event register clears every event bit written as 1 and leaves bits written as 0 unchanged.
- R8: `irq` is high exactly when the event register ANDed with the enable register is nonzero. An enable bit of 1 lets that pin through.
- R9: While `irq` is high, `irq_pin` gives the lowest-numbered pin that is both pending and enabled.
- R10: In the wide variant the pins marked by `INPUT_ONLY` (default pins 28–31, bits 3:0) ignore direction writes, read back 0 in the direction register and are never driven.
- R11: An edge detected in the same cycle as a write-one clear of that pin's event leaves the event set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (qualified by bus_sel) |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 32 | Pad levels, asynchronous |
| pad_out | output | 32 | Pad output value |
| pad_oe | output | 32 | Pad drive enable |
| irq | output | 1 | Combined interrupt request |
| irq_pin | output | 5 | Number of the first pending enabled pin |

## Verification
The hardest case to reach is an edge that is detected in exactly the cycle a software clear of the same event lands. The clear must be timed against the synchronizer delay. The stimulus changes the pad level, counts the two edges the synchronizer needs, and issues the write-one clear so that it lands on the third edge, where the event latch would otherwise update. Both sense variants are built side by side and share the pads, so each edge pattern is checked against two different sense configurations at once.

// File: rtl/gpio_irq_pkg.sv
// Shared definitions for the pin controller: register select codes taken
// from bus_addr[4:2] and the two-bit sense codes. Assumes word addressing.
package gpio_irq_pkg;
    typedef enum logic [2:0] {
        SEL_DIR    = 3'd0,
        SEL_ODEN   = 3'd1,
        SEL_DATA   = 3'd2,
        SEL_EVT    = 3'd3,
        SEL_ENA    = 3'd4,
        SEL_SENSE0 = 3'd5,
        SEL_SENSE1 = 3'd6
    } reg_sel_e;

    localparam logic [1:0] SNS_BOTH = 2'b00;
    localparam logic [1:0] SNS_RISE = 2'b01;
    localparam logic [1:0] SNS_FALL = 2'b10;
    localparam logic [1:0] SNS_NONE = 2'b11;
endpackage

// File: rtl/gpio_pin_sync.sv
// Two-flop synchronizer for the pad inputs. Assumes the pads are
// asynchronous to clk and that bits are independent (no bus coherency).
module gpio_pin_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    logic [N-1:0] stage1_q;
    logic [N-1:0] stage2_q;

    // Two register stages, reset low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_edge_events.sv
// Per-pin edge detector and write-one-to-clear event latch. The sense
// decode is picked per pin by generate according to SENSE_2BIT. Assumes
// the level input is already synchronous. A fresh edge wins over a clear.
module gpio_edge_events
    import gpio_irq_pkg::*;
#(
    parameter int N          = 32,
    parameter bit SENSE_2BIT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    input  logic [N-1:0] sense0,
    input  logic [N-1:0] sense1,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] events
);
    localparam int HALF = N / 2;

    logic [N-1:0] prev_q;
    logic [N-1:0] rise;
    logic [N-1:0] fall;
    logic [N-1:0] hit;

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;

    for (genvar b = 0; b < N; b++) begin : g_pin
        if (SENSE_2BIT) begin : g_wide
            logic [1:0] code;
            if (b >= HALF) begin : g_lo_pins
                assign code = sense0[2*(b-HALF)+1 -: 2];
            end else begin : g_hi_pins
                assign code = sense1[2*b+1 -: 2];
            end
            // Decode the two-bit sense code for this pin.
            always_comb begin
                unique case (code)
                    SNS_BOTH: hit[b] = rise[b] | fall[b];
                    SNS_RISE: hit[b] = rise[b];
                    SNS_FALL: hit[b] = fall[b];
                    default:  hit[b] = 1'b0;
                endcase
            end
        end else begin : g_narrow
            logic unused_s1;
            assign unused_s1 = sense1[b];
            assign hit[b] = fall[b] | (rise[b] & ~sense0[b]);
        end
    end

    // Track previous level and update event latches; new edge overrides clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            events <= '0;
        end else begin
            prev_q <= level;
            events <= (events & ~clr_mask) | hit;
        end
    end

    // R7: a cleared bit with no new edge is zero afterwards.
    p_clear_works_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (events & $past(clr_mask) & ~$past(hit)) == '0);
    // R11: a detected edge is always visible in the next cycle.
    p_edge_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (events & $past(hit)) == $past(hit));
endmodule

// File: rtl/gpio_first_pin.sv
// Finds the lowest-numbered pin (most significant set bit) of the gated
// event vector and reports its pin number plus a valid flag.
module gpio_first_pin #(
    parameter int N    = 32,
    parameter int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    pending,
    output logic            valid,
    output logic [IDXW-1:0] pin
);
    logic [IDXW-1:0] top_bit;

    // Scan upward so the highest set bit is kept.
    always_comb begin
        top_bit = '0;
        for (int b = 0; b < N; b++) begin
            if (pending[b]) top_bit = IDXW'(b);
        end
    end

    assign valid = |pending;
    assign pin   = IDXW'(N - 1) - top_bit;

    // R9: the reported pin is pending.
    p_pin_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> pending[IDXW'(N - 1) - pin]);
    // R9: no lower-numbered pin is pending.
    p_pin_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (pending & ~({N{1'b1}} >> pin)) == '0);
endmodule

// File: rtl/gpio_irq_port.sv
// Pin controller top: register file, pad drive, read mux, and the
// synchronizer, event and priority submodules. Pin n is bit N-1-n.
// Assumes N is 32 so that the two sense registers hold 16 pins each.
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int          N          = 32,
    parameter bit          SENSE_2BIT = 1'b0,
    parameter logic [31:0] INPUT_ONLY = 32'h0000_000F,
    parameter int          AW         = 5,
    parameter int          IDXW       = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [N-1:0]    bus_wdata,
    output logic [N-1:0]    bus_rdata,
    input  logic [N-1:0]    pad_in,
    output logic [N-1:0]    pad_out,
    output logic [N-1:0]    pad_oe,
    output logic            irq,
    output logic [IDXW-1:0] irq_pin
);
    localparam logic [N-1:0] LOCKED = SENSE_2BIT ? INPUT_ONLY[N-1:0] : '0;

    logic [N-1:0] dir_q, oden_q, data_q, ena_q, sense0_q, sense1_q;
    logic [N-1:0] level, events, clr_mask;
    reg_sel_e     rsel;
    logic         wr_en;

    assign rsel  = reg_sel_e'(bus_addr[4:2]);
    assign wr_en = bus_sel & bus_wr;

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= '0;
            oden_q   <= '0;
            data_q   <= '0;
            ena_q    <= '0;
            sense0_q <= '0;
            sense1_q <= '0;
        end else if (wr_en) begin
            case (rsel)
                SEL_DIR:    dir_q    <= bus_wdata & ~LOCKED;
                SEL_ODEN:   oden_q   <= bus_wdata;
                SEL_DATA:   data_q   <= bus_wdata;
                SEL_ENA:    ena_q    <= bus_wdata;
                SEL_SENSE0: sense0_q <= bus_wdata;
                SEL_SENSE1: if (SENSE_2BIT) sense1_q <= bus_wdata;
                default:    ;
            endcase
        end
    end

    assign clr_mask = (wr_en && rsel == SEL_EVT) ? bus_wdata : '0;

    gpio_pin_sync #(.N(N)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(level)
    );

    gpio_edge_events #(.N(N), .SENSE_2BIT(SENSE_2BIT)) u_events (
        .clk(clk), .rst_n(rst_n), .level(level), .sense0(sense0_q),
        .sense1(sense1_q), .clr_mask(clr_mask), .events(events)
    );

    gpio_first_pin #(.N(N), .IDXW(IDXW)) u_first (
        .clk(clk), .rst_n(rst_n), .pending(events & ena_q),
        .valid(irq), .pin(irq_pin)
    );

    // Pad drive: open-drain pins drive only a low level.
    assign pad_out = data_q & ~oden_q;
    assign pad_oe  = dir_q & (~oden_q | ~data_q);

    // Combinational register read.
    always_comb begin
        case (rsel)
            SEL_DIR:    bus_rdata = dir_q;
            SEL_ODEN:   bus_rdata = oden_q;
            SEL_DATA:   bus_rdata = (level & ~dir_q) | (data_q & dir_q);
            SEL_EVT:    bus_rdata = events;
            SEL_ENA:    bus_rdata = ena_q;
            SEL_SENSE0: bus_rdata = sense0_q;
            SEL_SENSE1: bus_rdata = sense1_q;
            default:    bus_rdata = '0;
        endcase
    end

    // R3: an open-drain pin driving the pad has its latch at 0.
    p_od_low_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & oden_q & data_q) == '0);
    // R10: input-only pins are never driven.
    p_locked_undriven_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & LOCKED) == '0);
    // R8: the request tracks enabled pending events.
    p_irq_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((events & ena_q) != '0));
endmodule

// File: tb/gpio_irq_port_tb_top.sv
// Directed bench: a narrow-sense (dut_i) and a wide-sense (dut_w_i) instance
// share the pads and bus data; each task checks its own scenario.
module gpio_irq_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_a = 1'b0, sel_b = 1'b0, wr = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0, pads = '0;
    logic [31:0] rd_a, rd_b, po_a, po_b, oe_a, oe_b;
    logic        irq_a, irq_b;
    logic [4:0]  pin_a, pin_b;
    int          n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    gpio_irq_port #(.SENSE_2BIT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_a), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd_a), .pad_in(pads), .pad_out(po_a),
        .pad_oe(oe_a), .irq(irq_a), .irq_pin(pin_a)
    );
    gpio_irq_port #(.SENSE_2BIT(1'b1)) dut_w_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_b), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd_b), .pad_in(pads), .pad_out(po_b),
        .pad_oe(oe_b), .irq(irq_b), .irq_pin(pin_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input bit b, input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        sel_a = !b; sel_b = b; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel_a = 1'b0; sel_b = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_reg(input bit b, input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = b ? rd_b : rd_a;
    endtask

    task automatic set_pads(input logic [31:0] v);
        @(negedge clk);
        pads = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_all();
        wr_reg(0, 5'h0C, 32'hFFFF_FFFF);
        wr_reg(1, 5'h0C, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int r = 0; r < 7; r++) begin
            rd_reg(0, 5'(r * 4), v); chk("R1 narrow reg", v, 0);
            rd_reg(1, 5'(r * 4), v); chk("R1 wide reg", v, 0);
        end
        chk("R1 irq", {30'd0, irq_a, irq_b}, 0);
        chk("R1 oe", oe_a | oe_b, 0);
    endtask

    task automatic t_pads();
        logic [31:0] v;
        wr_reg(0, 5'h00, 32'h8000_0001);
        wr_reg(0, 5'h08, 32'hC000_0001);
        chk("R2 oe pins 0,31", oe_a, 32'h8000_0001);
        rd_reg(0, 5'h08, v); chk("R4 data mux pads low", v, 32'h8000_0001);
        set_pads(32'h4000_0000);
        rd_reg(0, 5'h08, v); chk("R4 data mux pin1 high", v, 32'hC000_0001);
        wr_reg(0, 5'h04, 32'h8000_0000);
        chk("R3 od latch1 released", oe_a, 32'h0000_0001);
        wr_reg(0, 5'h08, 32'h4000_0001);
        chk("R3 od latch0 driven", oe_a, 32'h8000_0001);
        chk("R3 pad_out", po_a, 32'h4000_0001);
        wr_reg(0, 5'h00, 0); wr_reg(0, 5'h04, 0); wr_reg(0, 5'h08, 0);
        set_pads(0);
        clear_all();
        rd_reg(0, 5'h0C, v); chk("R7 clear all", v, 0);
    endtask

    task automatic t_sense_narrow();
        logic [31:0] v;
        wr_reg(0, 5'h14, 32'h8000_0000);
        set_pads(32'hC000_0000);
        rd_reg(0, 5'h0C, v); chk("R5 rise: pin0 fall-only", v, 32'h4000_0000);
        set_pads(0);
        rd_reg(0, 5'h0C, v); chk("R5 fall both pins", v, 32'hC000_0000);
        wr_reg(0, 5'h18, 32'hFFFF_FFFF);
        rd_reg(0, 5'h18, v); chk("R5 second sense ignored", v, 0);
        clear_all();
    endtask

    task automatic t_clear_and_irq();
        logic [31:0] v;
        set_pads(32'h2400_0000);
        rd_reg(0, 5'h0C, v); chk("R7 events pins 2,5", v, 32'h2400_0000);
        wr_reg(0, 5'h0C, 32'h2000_0000);
        rd_reg(0, 5'h0C, v); chk("R7 one-hot clear", v, 32'h0400_0000);
        wr_reg(0, 5'h0C, 0);
        rd_reg(0, 5'h0C, v); chk("R7 zero write keeps", v, 32'h0400_0000);
        chk("R8 masked no irq", {31'd0, irq_a}, 0);
        wr_reg(0, 5'h10, 32'h0400_0000);
        chk("R8 irq on enable", {31'd0, irq_a}, 1);
        chk("R9 pin 5", {27'd0, pin_a}, 5);
        set_pads(32'h0400_0000);
        wr_reg(0, 5'h10, 32'h2400_0000);
        chk("R9 lowest pin 2", {27'd0, pin_a}, 2);
        wr_reg(0, 5'h10, 32'h0400_0000);
        chk("R9 enable picks pin 5", {27'd0, pin_a}, 5);
        wr_reg(0, 5'h10, 0);
        chk("R8 irq off when disabled", {31'd0, irq_a}, 0);
        set_pads(0);
        clear_all();
    endtask

    task automatic t_sense_wide();
        logic [31:0] v;
        wr_reg(1, 5'h14, 32'h6C00_0000);
        wr_reg(1, 5'h18, 32'h8000_0000);
        set_pads(32'hF000_C000);
        rd_reg(1, 5'h0C, v); chk("R6 rising codes", v, 32'h9000_4000);
        set_pads(0);
        rd_reg(1, 5'h0C, v); chk("R6 falling codes", v, 32'hD000_C000);
        clear_all();
    endtask

    task automatic t_input_only();
        logic [31:0] v;
        wr_reg(1, 5'h00, 32'hFFFF_FFFF);
        rd_reg(1, 5'h00, v); chk("R10 locked dir reads 0", v, 32'hFFFF_FFF0);
        chk("R10 locked pads undriven", oe_b, 32'hFFFF_FFF0);
        wr_reg(0, 5'h00, 32'hFFFF_FFFF);
        rd_reg(0, 5'h00, v); chk("R10 narrow variant unlocked", v, 32'hFFFF_FFFF);
        wr_reg(0, 5'h00, 0); wr_reg(1, 5'h00, 0);
    endtask

    task automatic t_edge_vs_clear();
        logic [31:0] v;
        wr_reg(0, 5'h10, 32'h0000_0001);
        @(negedge clk);
        pads = 32'h0000_0001;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        sel_a = 1'b1; wr = 1'b1; addr = 5'h0C; wdata = 32'h0000_0001;
        @(negedge clk);
        sel_a = 1'b0; wr = 1'b0;
        rd_reg(0, 5'h0C, v); chk("R11 edge beats clear", v, 32'h0000_0001);
        chk("R9 pin 31", {27'd0, pin_a}, 31);
        wr_reg(0, 5'h0C, 32'h0000_0001);
        rd_reg(0, 5'h0C, v); chk("R7 later clear", v, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pads();
        t_sense_narrow();
        t_clear_and_irq();
        t_sense_wide();
        t_input_only();
        t_edge_vs_clear();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule